// File: doc/BRIEF.md
# Page-Mode OTP Programming Sequencer

This block is the host-side engine for byte-wide one-time-programmable memory. It receives commands over a valid/ready stream. Each command carries a 16-bit address, a data byte and an operation: program a byte, verify a byte, or write the lock bits. After reset the block performs the mode-entry handshake once. For every command it then generates the high-address latch pulse, the low address, the write data and the read or write strobe. All setups, holds, pulse widths and recovery gaps are counted in clock cycles.

The high address byte travels on the same 8-bit address port as the low byte. It is captured by the device on the falling edge of the latch pulse. The block remembers the page and the operation of the last byte access. It skips the latch phase when both are unchanged, so consecutive accesses inside one page cost only the low-address setup, the strobe and the recovery. The switch of the supply pin to programming voltage is modelled by a digital request output. Verify read-back is compared against the expected byte. A mismatch sets a sticky error flag and records the failing address and the byte actually read.

The command interface applies back-pressure by holding `cmd_ready` low for the whole waveform of the command in flight. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. While `cmd_valid` is high and the command has not been taken, the source must hold its fields stable.

Top module: `otp_prog_seq`

## Requirements
- R1: Reset starts the entry sequence. In the first phase `mode_sel`=1, `wr_stb_n`=0, `rd_stb_n`=1 and `acc_mode`=2'b01. The supply pin of the array chosen by `arr_sel` is low and the other pin is high (`vsup_lvl[0]` is the program array, `vsup_lvl[1]` is the character array). `mode_sel` falls next, and `wr_stb_n` rises after that. `cmd_ready` stays low until both have happened.
- R2: `cmd_ready` is high only when no command is in flight. It drops in the cycle after a command is taken and stays low until the recovery gap ends. The encoding of `cmd_op` is 2'b00 program, 2'b01 verify, and 2'b1x lock write.
- R3: A program or verify emits one `hi_lat` pulse with the high address byte on `addr_o` in three cases: it is the first byte access, its operation differs from the previous byte access, or its high byte differs from the previous byte access. In every other case no pulse is emitted. A lock write never pulses `hi_lat`, and the byte access after it always emits the pulse.
- R4: `acc_mode` changes only while `hi_lat` is low. It is stable for at least `T_SETUP` cycles before `hi_lat` rises. The high byte stays on `addr_o` for `T_HOLD` cycles after `hi_lat` falls.
- R5: `wr_stb_n` and `rd_stb_n` are never low together. While either one is low, `addr_o`, `dout`, `dout_en`, `acc_mode` and `vpp_raise` do not change.
- R6: A program uses `acc_mode`=2'b11 and drives the data byte on `dout` with `dout_en`=1. It pulses `wr_stb_n` low for `T_PGM` cycles. `vpp_raise` is high for at least `T_VPP` cycles before the first write pulse that needs it.
- R7: When the character array is selected, a program at an even address uses a write pulse of `T_PGM_SHORT` cycles. At an odd address it uses `T_PGM` cycles. The program array always uses `T_PGM`.
- R8: A verify uses `acc_mode`=2'b11 and keeps `vpp_raise` low. It pulses `rd_stb_n` low for `T_RD` cycles and captures `din` at the edge where `rd_stb_n` rises.
- R9: If a verified byte differs from the command's data byte, `vfy_err` goes high and stays high until reset. `err_addr` and `err_data` then hold the address and the byte read. A matching verify leaves all three unchanged.
- R10: A lock write uses `acc_mode`=2'b10 and drives the command byte on `dout`, with the lock bits in bits 1:0. It pulses `wr_stb_n` low for `T_PGM` cycles with `vpp_raise` high.
- R11: Two consecutive low pulses of the same strobe are separated by at least `T_GAP` high cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arr_sel | input | 1 | Array to program: 0 program array, 1 character array; static from reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken |
| cmd_op | input | 2 | Operation code |
| cmd_addr | input | 16 | Byte address (high byte is the page) |
| cmd_data | input | 8 | Data to write or expected read-back |
| mode_sel | output | 1 | Mode-entry select level |
| wr_stb_n | output | 1 | Write strobe, active low |
| rd_stb_n | output | 1 | Read strobe, active low |
| hi_lat | output | 1 | High-address latch pulse |
| acc_mode | output | 2 | Access mode select pair |
| addr_o | output | 8 | Multiplexed address port |
| dout | output | 8 | Data toward the device |
| dout_en | output | 1 | Data port driven by the block |
| din | input | 8 | Data from the device |
| vsup_lvl | output | 2 | Logic level of the two supply/select pins |
| vpp_raise | output | 1 | Request for programming voltage on the chosen supply pin |
| vfy_err | output | 1 | Sticky verify mismatch flag |
| err_addr | output | 16 | Address of the latest mismatch |
| err_data | output | 8 | Byte read at the latest mismatch |

## Verification
The assertions assume that `din` is meaningful only while `rd_stb_n` is low and has settled by the edge where it rises. They assume `arr_sel` holds its value from reset through the end of mode entry. They also assume the command fields stay stable while a command waits for `cmd_ready`. The bench device model honours these assumptions: it drives `din` combinationally from its byte store only during a read strobe, changes `arr_sel` only while reset is held, and keeps each command steady until the cycle in which it is taken.

// File: rtl/otp_seq_pkg.sv
package otp_seq_pkg;

  typedef enum logic [1:0] {
    OP_PROG = 2'b00,
    OP_VFY  = 2'b01,
    OP_LOCK = 2'b10
  } op_e;

  typedef enum logic [3:0] {
    ST_E0, ST_E1, ST_E2, ST_IDLE, ST_VPP, ST_PSET, ST_PALE,
    ST_PHOLD, ST_ASET, ST_STRB, ST_SHOLD, ST_GAP
  } st_e;

  localparam logic [1:0] AM_ENTRY = 2'b01;
  localparam logic [1:0] AM_BYTE  = 2'b11;
  localparam logic [1:0] AM_LOCK  = 2'b10;

  function automatic op_e op_of(input logic [1:0] code);
    if (code[1]) return OP_LOCK;
    if (code[0]) return OP_VFY;
    return OP_PROG;
  endfunction

endpackage

// File: rtl/otp_cyc_timer.sv
module otp_cyc_timer #(
  parameter int TW      = 4,
  parameter int RST_VAL = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          zero
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= TW'(RST_VAL);
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/otp_page_track.sv
module otp_page_track import otp_seq_pkg::*; #(
  parameter int HI_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            upd,
  input  op_e             op,
  input  logic [HI_W-1:0] hi,
  output logic            hit
);
  logic            vld_q;
  op_e             op_q;
  logic [HI_W-1:0] hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      op_q  <= OP_PROG;
      hi_q  <= '0;
    end else if (upd) begin
      vld_q <= (op != OP_LOCK);
      op_q  <= op;
      hi_q  <= hi;
    end
  end

  assign hit = vld_q && (op_q == op) && (hi_q == hi);
endmodule

// File: rtl/otp_vfy_cmp.sv
module otp_vfy_cmp #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chk,
  input  logic [DATA_W-1:0] exp_data,
  input  logic [DATA_W-1:0] got_data,
  input  logic [ADDR_W-1:0] addr,
  output logic              err,
  output logic [ADDR_W-1:0] err_addr,
  output logic [DATA_W-1:0] err_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err      <= 1'b0;
      err_addr <= '0;
      err_data <= '0;
    end else if (chk && (got_data != exp_data)) begin
      err      <= 1'b1;
      err_addr <= addr;
      err_data <= got_data;
    end
  end
endmodule

// File: rtl/otp_prog_seq.sv
module otp_prog_seq import otp_seq_pkg::*; #(
  parameter int PORT_W      = 8,
  parameter int DATA_W      = 8,
  parameter int T_SETUP     = 2,
  parameter int T_PALE      = 3,
  parameter int T_HOLD      = 2,
  parameter int T_PGM       = 10,
  parameter int T_PGM_SHORT = 4,
  parameter int T_RD        = 4,
  parameter int T_GAP       = 3,
  parameter int T_VPP       = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                arr_sel,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic [1:0]          cmd_op,
  input  logic [2*PORT_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0]   cmd_data,
  output logic                mode_sel,
  output logic                wr_stb_n,
  output logic                rd_stb_n,
  output logic                hi_lat,
  output logic [1:0]          acc_mode,
  output logic [PORT_W-1:0]   addr_o,
  output logic [DATA_W-1:0]   dout,
  output logic                dout_en,
  input  logic [DATA_W-1:0]   din,
  output logic [1:0]          vsup_lvl,
  output logic                vpp_raise,
  output logic                vfy_err,
  output logic [2*PORT_W-1:0] err_addr,
  output logic [DATA_W-1:0]   err_data
);
  localparam int ADDR_W = 2 * PORT_W;

  function automatic int max_t();
    int m;
    m = T_SETUP;
    if (T_PALE > m)      m = T_PALE;
    if (T_HOLD > m)      m = T_HOLD;
    if (T_PGM > m)       m = T_PGM;
    if (T_PGM_SHORT > m) m = T_PGM_SHORT;
    if (T_RD > m)        m = T_RD;
    if (T_GAP > m)       m = T_GAP;
    if (T_VPP > m)       m = T_VPP;
    return m;
  endfunction

  localparam int TMAX = max_t();
  localparam int TW   = $clog2(TMAX + 1);

  localparam logic [TW-1:0] L_SETUP = TW'(T_SETUP - 1);
  localparam logic [TW-1:0] L_PALE  = TW'(T_PALE - 1);
  localparam logic [TW-1:0] L_HOLD  = TW'(T_HOLD - 1);
  localparam logic [TW-1:0] L_PGM   = TW'(T_PGM - 1);
  localparam logic [TW-1:0] L_SHORT = TW'(T_PGM_SHORT - 1);
  localparam logic [TW-1:0] L_RD    = TW'(T_RD - 1);
  localparam logic [TW-1:0] L_GAP   = TW'(T_GAP - 1);
  localparam logic [TW-1:0] L_VPP   = TW'(T_VPP - 1);

  st_e               st_q, st_d;
  op_e               op_q, cmd_opd;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [1:0]        mode_q;
  logic              vpp_q, pale_q, arr_q;
  logic              accept, chk;
  logic              tmr_load, tmr_zero;
  logic [TW-1:0]     tmr_val, strb_len;
  logic              pg_hit, vpp_need, pale_need;
  logic              entry_lo, hi_phase, sel_arr;

  assign cmd_opd   = op_of(cmd_op);
  assign vpp_need  = (cmd_opd != OP_VFY);
  assign pale_need = (cmd_opd != OP_LOCK) && !pg_hit;

  otp_cyc_timer #(.TW(TW), .RST_VAL(T_SETUP - 1)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  otp_page_track #(.HI_W(PORT_W)) u_pg (
    .clk(clk), .rst_n(rst_n), .upd(accept), .op(cmd_opd),
    .hi(cmd_addr[ADDR_W-1:PORT_W]), .hit(pg_hit)
  );

  otp_vfy_cmp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .chk(chk), .exp_data(data_q), .got_data(din),
    .addr(addr_q), .err(vfy_err), .err_addr(err_addr), .err_data(err_data)
  );

  always_comb begin
    if (op_q == OP_VFY)                                strb_len = L_RD;
    else if (op_q == OP_PROG && arr_q && !addr_q[0])   strb_len = L_SHORT;
    else                                               strb_len = L_PGM;
  end

  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    accept   = 1'b0;
    chk      = 1'b0;
    case (st_q)
      ST_E0: if (tmr_zero) begin
        st_d = ST_E1; tmr_load = 1'b1; tmr_val = L_SETUP;
      end
      ST_E1: if (tmr_zero) begin
        st_d = ST_E2; tmr_load = 1'b1; tmr_val = L_SETUP;
      end
      ST_E2: if (tmr_zero) st_d = ST_IDLE;
      ST_IDLE: if (cmd_valid) begin
        accept   = 1'b1;
        tmr_load = 1'b1;
        if (vpp_need != vpp_q) begin
          st_d = ST_VPP; tmr_val = L_VPP;
        end else begin
          st_d = pale_need ? ST_PSET : ST_ASET; tmr_val = L_SETUP;
        end
      end
      ST_VPP: if (tmr_zero) begin
        st_d = pale_q ? ST_PSET : ST_ASET; tmr_load = 1'b1; tmr_val = L_SETUP;
      end
      ST_PSET: if (tmr_zero) begin
        st_d = ST_PALE; tmr_load = 1'b1; tmr_val = L_PALE;
      end
      ST_PALE: if (tmr_zero) begin
        st_d = ST_PHOLD; tmr_load = 1'b1; tmr_val = L_HOLD;
      end
      ST_PHOLD: if (tmr_zero) begin
        st_d = ST_ASET; tmr_load = 1'b1; tmr_val = L_SETUP;
      end
      ST_ASET: if (tmr_zero) begin
        st_d = ST_STRB; tmr_load = 1'b1; tmr_val = strb_len;
      end
      ST_STRB: if (tmr_zero) begin
        st_d = ST_SHOLD; tmr_load = 1'b1; tmr_val = L_HOLD;
        chk  = (op_q == OP_VFY);
      end
      ST_SHOLD: if (tmr_zero) begin
        st_d = ST_GAP; tmr_load = 1'b1; tmr_val = L_GAP;
      end
      ST_GAP: if (tmr_zero) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_E0;
      op_q   <= OP_PROG;
      addr_q <= '0;
      data_q <= '0;
      mode_q <= AM_ENTRY;
      vpp_q  <= 1'b0;
      pale_q <= 1'b0;
      arr_q  <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_E0) arr_q <= arr_sel;
      if (accept) begin
        op_q   <= cmd_opd;
        addr_q <= cmd_addr;
        data_q <= cmd_data;
        mode_q <= (cmd_opd == OP_LOCK) ? AM_LOCK : AM_BYTE;
        vpp_q  <= vpp_need;
        pale_q <= pale_need;
      end
    end
  end

  assign entry_lo  = (st_q == ST_E0) || (st_q == ST_E1);
  assign hi_phase  = (st_q == ST_PSET) || (st_q == ST_PALE) || (st_q == ST_PHOLD);
  assign sel_arr   = (st_q == ST_E0) ? arr_sel : arr_q;

  assign cmd_ready = (st_q == ST_IDLE);
  assign mode_sel  = (st_q == ST_E0);
  assign wr_stb_n  = !(entry_lo || (st_q == ST_STRB && op_q != OP_VFY));
  assign rd_stb_n  = !(st_q == ST_STRB && op_q == OP_VFY);
  assign hi_lat    = (st_q == ST_PALE);
  assign acc_mode  = mode_q;
  assign addr_o    = hi_phase ? addr_q[ADDR_W-1:PORT_W] : addr_q[PORT_W-1:0];
  assign dout      = data_q;
  assign dout_en   = (op_q != OP_VFY) &&
                     ((st_q == ST_ASET) || (st_q == ST_STRB) || (st_q == ST_SHOLD));
  assign vsup_lvl[0] = !(entry_lo && !sel_arr);
  assign vsup_lvl[1] = !(entry_lo && sel_arr);
  assign vpp_raise = vpp_q;
endmodule

// File: rtl/otp_prog_seq_chk.sv
module otp_prog_seq_chk #(
  parameter int PORT_W = 8,
  parameter int DATA_W = 8,
  parameter int T_GAP  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_sel,
  input logic              wr_stb_n,
  input logic              rd_stb_n,
  input logic              hi_lat,
  input logic [1:0]        acc_mode,
  input logic [PORT_W-1:0] addr_o,
  input logic [DATA_W-1:0] dout,
  input logic              dout_en,
  input logic              vpp_raise,
  input logic              cmd_ready
);
  localparam int GW = $clog2(T_GAP + 1) + 1;

  logic          live;
  logic [GW-1:0] wr_hi, rd_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live  <= 1'b0;
      wr_hi <= '0;
      rd_hi <= '0;
    end else begin
      live <= live || (!mode_sel && wr_stb_n);
      if (!wr_stb_n)                 wr_hi <= '0;
      else if (wr_hi < GW'(T_GAP))   wr_hi <= wr_hi + 1'b1;
      if (!rd_stb_n)                 rd_hi <= '0;
      else if (rd_hi < GW'(T_GAP))   rd_hi <= rd_hi + 1'b1;
    end
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!wr_stb_n && !rd_stb_n)); // R5
  AST_STROBE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (live && (!wr_stb_n || !rd_stb_n)) |-> ($stable(addr_o) && $stable(dout) &&
      $stable(dout_en) && $stable(acc_mode) && $stable(vpp_raise))); // R5
  AST_MODE_LATCH_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !$stable(acc_mode)) |-> (!hi_lat && !$past(hi_lat))); // R4
  AST_LATCH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    hi_lat |-> (wr_stb_n && rd_stb_n)); // R3
  AST_VPP_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !wr_stb_n) |-> vpp_raise); // R6
  AST_VFY_LOGIC: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb_n |-> !vpp_raise); // R8
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (wr_stb_n && rd_stb_n && !hi_lat)); // R2
  AST_WR_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $fell(wr_stb_n)) |-> (wr_hi >= GW'(T_GAP))); // R11
  AST_RD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $fell(rd_stb_n)) |-> (rd_hi >= GW'(T_GAP))); // R11
endmodule

bind otp_prog_seq otp_prog_seq_chk #(.PORT_W(PORT_W), .DATA_W(DATA_W), .T_GAP(T_GAP)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .wr_stb_n(wr_stb_n),
  .rd_stb_n(rd_stb_n), .hi_lat(hi_lat), .acc_mode(acc_mode), .addr_o(addr_o),
  .dout(dout), .dout_en(dout_en), .vpp_raise(vpp_raise), .cmd_ready(cmd_ready)
);

// File: tb/sim_otp_prog_seq.sv
module sim_otp_prog_seq;
  localparam int T_SETUP = 2, T_PALE = 3, T_HOLD = 2, T_PGM = 10;
  localparam int T_PGM_SHORT = 4, T_RD = 4, T_GAP = 3, T_VPP = 5;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, arr_sel, cmd_valid, cmd_ready;
  logic [1:0]  cmd_op;
  logic [15:0] cmd_addr;
  logic [7:0]  cmd_data;
  logic        mode_sel, wr_stb_n, rd_stb_n, hi_lat, dout_en, vpp_raise, vfy_err;
  logic [1:0]  acc_mode, vsup_lvl;
  logic [7:0]  addr_o, dout, din, err_data;
  logic [15:0] err_addr;

  otp_prog_seq #(
    .T_SETUP(T_SETUP), .T_PALE(T_PALE), .T_HOLD(T_HOLD), .T_PGM(T_PGM),
    .T_PGM_SHORT(T_PGM_SHORT), .T_RD(T_RD), .T_GAP(T_GAP), .T_VPP(T_VPP)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .arr_sel(arr_sel), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .mode_sel(mode_sel), .wr_stb_n(wr_stb_n), .rd_stb_n(rd_stb_n), .hi_lat(hi_lat),
    .acc_mode(acc_mode), .addr_o(addr_o), .dout(dout), .dout_en(dout_en), .din(din),
    .vsup_lvl(vsup_lvl), .vpp_raise(vpp_raise), .vfy_err(vfy_err),
    .err_addr(err_addr), .err_data(err_data)
  );

  // device model
  logic [7:0] hi_q = 8'h00;
  logic [7:0] mem [0:1023];
  logic [1:0] lock_val = 2'b11;
  int lock_cnt = 0, pale_cnt = 0;
  wire  [9:0] didx = {hi_q[1:0], addr_o};

  initial for (int i = 0; i < 1024; i++) mem[i] = 8'h00;

  always @(negedge hi_lat) hi_q = addr_o;
  always @(posedge hi_lat) pale_cnt++;
  always @(posedge wr_stb_n) begin
    if (!mode_sel && rst_n) begin
      if (acc_mode == 2'b11) mem[didx] = dout;
      else if (acc_mode == 2'b10) begin
        lock_val = dout[1:0];
        lock_cnt++;
      end
    end
  end
  assign din = (!rd_stb_n && acc_mode == 2'b11) ? mem[didx] : 8'h00;

  // pulse monitors sampled at the falling clock edge
  int wr_cur = 0, wr_last = 0, wr_hi = 0, wr_gap = 0;
  int rd_cur = 0, rd_last = 0, rd_hi = 0, rd_gap = 0;
  int vpp_cnt = 0, vpp_lead = 0;
  always @(negedge clk) begin
    if (rst_n && !mode_sel && !wr_stb_n) begin
      if (wr_cur == 0) begin vpp_lead = vpp_cnt; wr_gap = wr_hi; end
      wr_cur++; wr_hi = 0;
    end else begin
      if (wr_cur != 0) wr_last = wr_cur;
      wr_cur = 0;
      wr_hi++;
    end
    if (rst_n && !rd_stb_n) begin
      if (rd_cur == 0) rd_gap = rd_hi;
      rd_cur++; rd_hi = 0;
    end else begin
      if (rd_cur != 0) rd_last = rd_cur;
      rd_cur = 0;
      rd_hi++;
    end
    if (vpp_raise) vpp_cnt++; else vpp_cnt = 0;
  end

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic arr);
    rst_n = 1'b0; arr_sel = arr; cmd_valid = 1'b0;
    cmd_op = 2'b00; cmd_addr = 16'h0; cmd_data = 8'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
  endtask

  task automatic send(input logic [1:0] op, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cmd_op = op; cmd_addr = a; cmd_data = d; cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(cmd_ready == 1'b0, "R2 ready low after accept", cmd_ready, 0);
    wait_idle();
  endtask

  task automatic t_entry(input logic arr);
    int t_sel = -1, t_wr = -1, t_rdy = -1;
    do_reset(arr);
    chk(mode_sel == 1'b1 && wr_stb_n == 1'b0 && rd_stb_n == 1'b1, "R1 entry strobes",
        {mode_sel, wr_stb_n, rd_stb_n}, 3'b101);
    chk(acc_mode == 2'b01, "R1 entry mode", acc_mode, 2'b01);
    chk(vsup_lvl == (arr ? 2'b01 : 2'b10), "R1 entry supply levels", vsup_lvl,
        arr ? 2'b01 : 2'b10);
    chk(cmd_ready == 1'b0, "R1 not ready in entry", cmd_ready, 0);
    for (int n = 0; n < 40; n++) begin
      if (t_sel < 0 && !mode_sel) t_sel = n;
      if (t_wr < 0 && t_sel >= 0 && wr_stb_n) t_wr = n;
      if (t_rdy < 0 && cmd_ready) t_rdy = n;
      @(negedge clk);
    end
    chk(t_sel >= 0 && t_wr > t_sel, "R1 select falls before write strobe rises", t_wr, t_sel + 1);
    chk(t_rdy >= t_wr && t_wr >= 0, "R1 ready only after entry", t_rdy, t_wr);
    chk(vsup_lvl == 2'b11, "R1 supply pins high after entry", vsup_lvl, 2'b11);
  endtask

  task automatic t_prog_page();
    int p0 = pale_cnt;
    send(2'b00, 16'h0310, 8'hA1);
    chk(vpp_lead >= T_VPP, "R6 supply raised before first write", vpp_lead, T_VPP);
    chk(wr_last == T_PGM, "R6 program pulse width", wr_last, T_PGM);
    send(2'b00, 16'h0311, 8'hB2);
    send(2'b00, 16'h0312, 8'hC3);
    chk(pale_cnt - p0 == 1, "R3 one latch for one page", pale_cnt - p0, 1);
    chk(hi_q == 8'h03, "R4 high byte latched", hi_q, 8'h03);
    chk(mem[10'h310] == 8'hA1 && mem[10'h311] == 8'hB2 && mem[10'h312] == 8'hC3,
        "R6 bytes written", mem[10'h312], 8'hC3);
    chk(wr_gap >= T_GAP, "R11 write recovery", wr_gap, T_GAP);
    chk(acc_mode == 2'b11, "R6 byte access mode", acc_mode, 2'b11);
  endtask

  task automatic t_page_change();
    int p0 = pale_cnt;
    send(2'b00, 16'h0400, 8'hD4);
    chk(pale_cnt - p0 == 1, "R3 latch on page change", pale_cnt - p0, 1);
    chk(hi_q == 8'h04, "R3 new high byte", hi_q, 8'h04);
    chk(mem[10'h000] == 8'hD4, "R6 byte on new page", mem[10'h000], 8'hD4);
  endtask

  task automatic t_verify();
    int p0 = pale_cnt;
    send(2'b01, 16'h0400, 8'hD4);
    chk(pale_cnt - p0 == 1, "R3 latch on mode change", pale_cnt - p0, 1);
    chk(rd_last == T_RD, "R8 read pulse width", rd_last, T_RD);
    chk(vpp_raise == 1'b0, "R8 supply at logic level", vpp_raise, 0);
    send(2'b01, 16'h0310, 8'hA1);
    chk(pale_cnt - p0 == 2, "R3 latch on page change in verify", pale_cnt - p0, 2);
    chk(vfy_err == 1'b0, "R9 matching verify no error", vfy_err, 0);
    chk(rd_gap >= T_GAP, "R11 read recovery", rd_gap, T_GAP);
  endtask

  task automatic t_mismatch();
    int p0 = pale_cnt;
    mem[10'h311] = 8'h5A;
    send(2'b01, 16'h0311, 8'hB2);
    chk(pale_cnt == p0, "R3 no latch same page and mode", pale_cnt - p0, 0);
    chk(vfy_err == 1'b1, "R9 mismatch flagged", vfy_err, 1);
    chk(err_addr == 16'h0311, "R9 failing address", err_addr, 16'h0311);
    chk(err_data == 8'h5A, "R9 byte read", err_data, 8'h5A);
    send(2'b01, 16'h0310, 8'hA1);
    chk(vfy_err == 1'b1 && err_addr == 16'h0311 && err_data == 8'h5A,
        "R9 match leaves error record", err_addr, 16'h0311);
  endtask

  task automatic t_lock();
    int p0, l0;
    send(2'b00, 16'h0313, 8'hE5);
    p0 = pale_cnt; l0 = lock_cnt;
    send(2'b10, 16'h0000, 8'h02);
    chk(lock_cnt - l0 == 1 && lock_val == 2'b10, "R10 lock bits written", lock_val, 2'b10);
    chk(pale_cnt == p0, "R10 no latch for lock", pale_cnt - p0, 0);
    chk(wr_last == T_PGM, "R10 lock pulse width", wr_last, T_PGM);
    chk(acc_mode == 2'b10, "R10 lock access mode", acc_mode, 2'b10);
    send(2'b00, 16'h0314, 8'hF6);
    chk(pale_cnt - p0 == 1, "R3 latch after lock", pale_cnt - p0, 1);
    chk(mem[10'h314] == 8'hF6, "R6 byte after lock", mem[10'h314], 8'hF6);
  endtask

  task automatic t_char();
    send(2'b00, 16'h0020, 8'h3C);
    chk(wr_last == T_PGM_SHORT, "R7 short pulse at even address", wr_last, T_PGM_SHORT);
    send(2'b00, 16'h0021, 8'h05);
    chk(wr_last == T_PGM, "R7 full pulse at odd address", wr_last, T_PGM);
    chk(mem[10'h020] == 8'h3C && mem[10'h021] == 8'h05, "R7 char bytes written",
        mem[10'h021], 8'h05);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL R2 watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_entry(1'b0);
    t_prog_page();
    t_page_change();
    t_verify();
    t_mismatch();
    t_lock();
    t_entry(1'b1);
    t_char();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule